// File: doc/BRIEF.md
# Byte-Wide Multicycle Processor Datapath

This block is the datapath half of a small multicycle processor whose data, addresses and program counter are all one byte wide. It contains the program counter, a 32-bit instruction register, an eight-entry register file, a two-operand ALU with its input selectors, and two holding registers. One captures the byte read from memory. The other captures the ALU result. An external control sequencer drives every select and enable. The datapath returns the assembled instruction word, a zero flag for branch decisions, the memory address and the memory write data.

An instruction is 32 bits wide but the memory bus carries one byte, so the controller fetches it over four cycles. Each cycle it loads one byte lane of the instruction register, starting with the least significant lane. In each of those cycles it also routes the program counter and the constant one through the ALU and writes the sum back, so the counter steps by one byte per fetched byte. Later cycles reuse the same ALU for register arithmetic, address generation and branch comparison. The instruction word carries these fields: opcode in bits 31:26, source registers in bits 25:21 and 20:16, destination register in bits 15:11, and immediate and function code in the low byte.

Top module: `byte_cpu_datapath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter, the instruction register and both holding registers are cleared to zero.
- R2: Register 0 always reads as zero, even after a write to it. Read port 1 is addressed by instruction bits 23:21 and read port 2 by bits 18:16. Both read ports are combinational. A write takes effect at the rising edge only while `reg_we` is high. With `reg_we` low, the register contents do not change.
- R3: The write address is instruction bits 13:11 when `dst_sel` is 1, and instruction bits 18:16 when `dst_sel` is 0.
- R4: Bit i of `ir_we` loads `mem_rdata` into instruction bits 8i+7:8i at the rising edge. Lanes whose enable bit is low keep their value.
- R5: With `srca_sel`=0, `srcb_sel`=01, `alu_op`=010 and `pc_src`=00, each edge with `pc_en` high adds 1 to the program counter. With `pc_en` low, the counter holds.
- R6: The ALU codes are as follows:
  - 010 gives a+b.
  - 110 gives a+~b+1, that is a−b modulo 256.
  - 000 gives a AND b.
  - 001 gives a OR b.
  - 111 gives 0 or 1 equal to bit 7 of a−b modulo 256.
- R7: `zero` is 1 exactly when the current ALU result is 0.
- R8: Operand A is the program counter when `srca_sel`=0 and read port 1 when it is 1. Operand B depends on `srcb_sel`:
  - 00 selects read port 2.
  - 01 selects the constant 1.
  - 10 selects instruction bits 7:0.
  - 11 selects instruction bits 5:0 followed by two zero bits.
- R9: The value written to the program counter depends on `pc_src`:
  - 00 selects the live ALU result.
  - 01 selects the registered ALU result.
  - 10 selects instruction bits 5:0 followed by two zero bits.
- R10: The ALU holding register captures the ALU result on every edge. `mem_addr` is the program counter when `addr_sel`=0 and the ALU holding register when it is 1.
- R11: The memory-data register captures `mem_rdata` on every edge. The register file writes that register when `wb_mem_sel`=1 and the ALU holding register when it is 0. `mem_wdata` is read port 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rdata | input | 8 | Byte read from memory |
| pc_en | input | 1 | Program counter write enable |
| ir_we | input | 4 | Instruction register byte-lane enables, bit 0 = least significant lane |
| srca_sel | input | 1 | ALU operand A select |
| srcb_sel | input | 2 | ALU operand B select |
| alu_op | input | 3 | ALU operation code |
| pc_src | input | 2 | Program counter source select |
| addr_sel | input | 1 | Memory address select |
| dst_sel | input | 1 | Register write address field select |
| wb_mem_sel | input | 1 | Register write data select |
| reg_we | input | 1 | Register file write enable |
| instr | output | 32 | Assembled instruction word |
| zero | output | 1 | ALU result is zero |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The ALU is swept over every pair of source registers and all five operation codes, with two different sets of register contents. The values include 00, 01, 7F, 80, 81, FE and FF, so that carry, wrap-around, sign-bit and overflow cases all appear. This separates set-on-less-than from a true signed compare and shows whether the subtractor's inversion and carry-in are present. Pairs that read register 0 show whether the hardwired zero holds. Pairs that read the same register twice give a zero difference and must raise the flag. The fetch sequence, the lane-by-lane loads, the two immediate scalings, the three counter sources and the two write-back paths are each driven with distinct bytes. A wrong lane order, a missing shift or a swapped select therefore produces a different value at the ports.

// File: rtl/bdp_pkg.sv
// Package: shared constants and select encodings for the byte-wide datapath.
// Assumes: the control sequencer uses exactly these encodings.
package bdp_pkg;

    // Operand B sources
    typedef enum logic [1:0] {
        SRCB_REG2  = 2'b00,
        SRCB_ONE   = 2'b01,
        SRCB_IMM   = 2'b10,
        SRCB_IMMX4 = 2'b11
    } srcb_e;

    // Program counter sources
    typedef enum logic [1:0] {
        PCS_ALU   = 2'b00,
        PCS_ALUQ  = 2'b01,
        PCS_JUMP  = 2'b10,
        PCS_HOLD  = 2'b11
    } pcsrc_e;

    // ALU operation codes; bit 2 doubles as the invert/carry-in control
    localparam logic [2:0] OP_AND = 3'b000;
    localparam logic [2:0] OP_OR  = 3'b001;
    localparam logic [2:0] OP_ADD = 3'b010;
    localparam logic [2:0] OP_SUB = 3'b110;
    localparam logic [2:0] OP_SLT = 3'b111;

    // Instruction field positions (fixed 32-bit format)
    localparam int RS_LSB = 21;
    localparam int RT_LSB = 16;
    localparam int RD_LSB = 11;

endpackage

// File: rtl/bdp_regfile.sv
// Module: bdp_regfile
// Three-port register file: two combinational reads, one synchronous write.
// Assumes: entry 0 is never stored and always reads as zero; contents have
// no reset, software initialises registers before use.
module bdp_regfile #(
    parameter int DW = 8,
    parameter int RB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RB-1:0] ra1,
    input  logic [RB-1:0] ra2,
    input  logic [RB-1:0] wa,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2
);
    localparam int NREG = 1 << RB;

    logic [DW-1:0] mem_q [NREG];

    // Write port: store on the rising edge when enabled, never into entry 0
    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            mem_q[wa] <= wd;
        end
    end

    // Read ports: entry 0 is hardwired to zero
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : mem_q[ra1];
        rd2 = (ra2 == '0) ? '0 : mem_q[ra2];
    end

    // R2: a disabled write leaves what port 2 reads unchanged
    a_r2_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (ra2 != $past(ra2)) || (rd2 == $past(rd2)));

endmodule

// File: rtl/bdp_alu.sv
// Module: bdp_alu
// Two-operand ALU with AND, OR, add, subtract and set-on-less-than.
// Assumes: op[2] inverts operand B and supplies the carry-in; less-than is
// the top bit of the difference (no overflow correction).
module bdp_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [2:0]    op,
    output logic [DW-1:0] y,
    output logic          zero
);
    logic [DW-1:0] b_eff;
    logic [DW-1:0] sum;

    // Adder input: optional inversion for subtraction
    always_comb b_eff = op[2] ? ~b : b;

    // Shared adder with op[2] as carry-in
    always_comb sum = a + b_eff + {{(DW-1){1'b0}}, op[2]};

    // Result select on the low two operation bits
    always_comb begin
        case (op[1:0])
            2'b00:   y = a & b;
            2'b01:   y = a | b;
            2'b10:   y = sum;
            default: y = {{(DW-1){1'b0}}, sum[DW-1]};
        endcase
    end

    // Zero detect for branch decisions
    always_comb zero = (y == '0);

endmodule

// File: rtl/bdp_instr_reg.sv
// Module: bdp_instr_reg
// Instruction register assembled from byte lanes, one enable per lane.
// Assumes: lanes are loaded straight from the memory read bus.
module bdp_instr_reg #(
    parameter int DW    = 8,
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    we,
    input  logic [DW-1:0]       d,
    output logic [DW*LANES-1:0] q
);
    logic [DW-1:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane register: clear on reset, load when its enable is set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (we[g]) begin
                lane_q[g] <= d;
            end
        end
        assign q[g*DW +: DW] = lane_q[g];
    end

    // R4: with no lane enabled the word is unchanged
    a_r4_lanes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (we == '0) |=> $stable(q));

    // R4: lane 0 alone takes the bus byte, upper lanes keep their value
    a_r4_lane0_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we == {{(LANES-1){1'b0}}, 1'b1}) |=>
        (q[DW-1:0] == $past(d)) && (q[DW*LANES-1:DW] == $past(q[DW*LANES-1:DW])));

endmodule

// File: rtl/byte_cpu_datapath.sv
// Module: byte_cpu_datapath
// Datapath of a byte-wide multicycle processor: program counter, instruction
// register, register file, ALU with operand selectors, memory-data and
// ALU-output holding registers.
// Assumes: an external sequencer drives all selects; memory is read
// asynchronously onto mem_rdata; synchronous active-low reset.
module byte_cpu_datapath #(
    parameter int DW = 8,
    parameter int RB = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 pc_en,
    input  logic [32/DW-1:0]     ir_we,
    input  logic                 srca_sel,
    input  logic [1:0]           srcb_sel,
    input  logic [2:0]           alu_op,
    input  logic [1:0]           pc_src,
    input  logic                 addr_sel,
    input  logic                 dst_sel,
    input  logic                 wb_mem_sel,
    input  logic                 reg_we,
    output logic [31:0]          instr,
    output logic                 zero,
    output logic [DW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata
);
    import bdp_pkg::*;

    localparam int IW    = 32;
    localparam int LANES = IW / DW;

    logic [DW-1:0] pc_q, pc_next;
    logic [DW-1:0] mdr_q, alu_q;
    logic [DW-1:0] rd1, rd2, wd;
    logic [DW-1:0] opa, opb, alu_y;
    logic [DW-1:0] imm, imm_x4;
    logic [RB-1:0] ra1, ra2, wa;
    logic          alu_zero;

    // Instruction register
    bdp_instr_reg #(.DW(DW), .LANES(LANES)) i_ir (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ir_we),
        .d     (mem_rdata),
        .q     (instr)
    );

    // Field extraction: register numbers and the two immediate forms
    always_comb begin
        ra1    = instr[RS_LSB +: RB];
        ra2    = instr[RT_LSB +: RB];
        wa     = dst_sel ? instr[RD_LSB +: RB] : instr[RT_LSB +: RB];
        imm    = instr[DW-1:0];
        imm_x4 = {instr[DW-3:0], 2'b00};
    end

    // Register write data select
    always_comb wd = wb_mem_sel ? mdr_q : alu_q;

    bdp_regfile #(.DW(DW), .RB(RB)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .ra1   (ra1),
        .ra2   (ra2),
        .wa    (wa),
        .wd    (wd),
        .rd1   (rd1),
        .rd2   (rd2)
    );

    // Operand A select
    always_comb opa = srca_sel ? rd1 : pc_q;

    // Operand B select
    always_comb begin
        case (srcb_e'(srcb_sel))
            SRCB_REG2: opb = rd2;
            SRCB_ONE:  opb = {{(DW-1){1'b0}}, 1'b1};
            SRCB_IMM:  opb = imm;
            default:   opb = imm_x4;
        endcase
    end

    bdp_alu #(.DW(DW)) i_alu (
        .a    (opa),
        .b    (opb),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Program counter source select
    always_comb begin
        case (pcsrc_e'(pc_src))
            PCS_ALU:  pc_next = alu_y;
            PCS_ALUQ: pc_next = alu_q;
            PCS_JUMP: pc_next = imm_x4;
            default:  pc_next = pc_q;
        endcase
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (pc_en) begin
            pc_q <= pc_next;
        end
    end

    // Holding registers: memory data and ALU result, loaded every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
            alu_q <= '0;
        end else begin
            mdr_q <= mem_rdata;
            alu_q <= alu_y;
        end
    end

    // Output drive
    always_comb begin
        zero      = alu_zero;
        mem_addr  = addr_sel ? alu_q : pc_q;
        mem_wdata = rd2;
    end

    // R5: counter holds while its enable is low
    a_r5_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_en |=> (pc_q == $past(pc_q)));

    // R5: fetch setting advances the counter by one
    a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en && !srca_sel && (srcb_sel == 2'b01) && (alu_op == 3'b010) &&
         (pc_src == 2'b00)) |=> (pc_q == $past(pc_q) + 1'b1));

    // R7 / R10: a zero flag means the captured result is zero
    a_r7_zero_capture: assert property (@(posedge clk) disable iff (!rst_n)
        zero |=> (alu_q == '0));

    // R11: memory-data register follows the read bus by one cycle
    a_r11_mdr_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mdr_q == $past(mem_rdata)));

endmodule

// File: tb/test_byte_cpu_datapath.sv
`timescale 1ns/1ps
module test_byte_cpu_datapath;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  mem_rdata;
    logic        pc_en;
    logic [3:0]  ir_we;
    logic        srca_sel;
    logic [1:0]  srcb_sel;
    logic [2:0]  alu_op;
    logic [1:0]  pc_src;
    logic        addr_sel;
    logic        dst_sel;
    logic        wb_mem_sel;
    logic        reg_we;
    logic [31:0] instr;
    logic        zero;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_wdata;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] model_reg [8];

    byte_cpu_datapath i_byte_cpu_datapath (
        .clk, .rst_n, .mem_rdata, .pc_en, .ir_we, .srca_sel, .srcb_sel,
        .alu_op, .pc_src, .addr_sel, .dst_sel, .wb_mem_sel, .reg_we,
        .instr, .zero, .mem_addr, .mem_wdata
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    function automatic logic [31:0] mk(input int rs, input int rt, input int rd,
                                       input logic [7:0] imm);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 3'b000, imm};
    endfunction

    function automatic logic [7:0] ref_alu(input logic [7:0] a, input logic [7:0] b,
                                           input logic [2:0] op);
        logic [7:0] d;
        d = a - b;
        case (op)
            3'b010:  return a + b;
            3'b110:  return d;
            3'b000:  return a & b;
            3'b001:  return a | b;
            default: return {7'b0, d[7]};
        endcase
    endfunction

    function automatic logic [2:0] op_of(input int o);
        case (o)
            0:       return 3'b010;
            1:       return 3'b110;
            2:       return 3'b000;
            3:       return 3'b001;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [7:0] val_of(input int r, input int k);
        logic [7:0] v0 [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h0F};
        logic [7:0] v1 [8] = '{8'h00, 8'h02, 8'hFE, 8'h81, 8'h7E, 8'h33, 8'hC3, 8'h01};
        return (r == 0) ? v0[k] : v1[k];
    endfunction

    task automatic quiet();
        pc_en = 0; ir_we = 0; reg_we = 0; addr_sel = 0;
    endtask

    // Load the instruction register lane by lane with the counter held
    task automatic load_ir(input logic [31:0] w);
        for (int i = 0; i < 4; i++) begin
            mem_rdata = w[8*i +: 8];
            ir_we = 4'(1 << i);
            tick();
        end
        ir_we = 0;
    endtask

    // Write a register through the memory-data path (R11, R3)
    task automatic write_reg(input int k, input logic [7:0] v);
        load_ir(mk(0, 0, k, 8'h00));
        dst_sel = 1; mem_rdata = v; wb_mem_sel = 1;
        tick();
        reg_we = 1;
        tick();
        reg_we = 0;
        if (k != 0) model_reg[k] = v;
    endtask

    task automatic alu_vec(input int a, input int b, input logic [2:0] op);
        logic [7:0] e;
        load_ir(mk(a, b, 0, 8'h00));
        srca_sel = 1; srcb_sel = 2'b00; alu_op = op;
        e = ref_alu(model_reg[a], model_reg[b], op);
        settle();
        chk("R7 zero flag", 32'(zero), 32'(e == 8'h00));
        tick();
        addr_sel = 1;
        settle();
        chk("R6 alu result", 32'(mem_addr), 32'(e));
        addr_sel = 0;
    endtask

    initial begin
        logic [31:0] w;
        logic [7:0]  e;
        for (int k = 0; k < 8; k++) model_reg[k] = 8'h00;
        rst_n = 0; mem_rdata = 8'h3C; quiet();
        srca_sel = 0; srcb_sel = 2'b01; alu_op = 3'b010; pc_src = 2'b00;
        dst_sel = 0; wb_mem_sel = 0;
        tick(); tick();
        settle();
        chk("R1 reset pc", 32'(mem_addr), 32'h0);
        chk("R1 reset instr", instr, 32'h0);
        rst_n = 1;

        // R5 / R4: four-byte fetch with the counter stepping per byte
        w = 32'hA1B2C3D4;
        pc_en = 1;
        for (int i = 0; i < 4; i++) begin
            mem_rdata = w[8*i +: 8]; ir_we = 4'(1 << i);
            tick(); settle();
            chk("R5 fetch pc step", 32'(mem_addr), 32'(i + 1));
        end
        ir_we = 0; pc_en = 0;
        chk("R4 fetched word", instr, w);
        mem_rdata = 8'h99; tick(); tick(); settle();
        chk("R5 pc hold", 32'(mem_addr), 32'd4);
        chk("R4 no lane enabled", instr, w);
        ir_we = 4'b0100; mem_rdata = 8'h5A; tick(); ir_we = 0; settle();
        chk("R4 single lane 2", instr, 32'hA15AC3D4);

        // R2: register 0 ignores a write
        write_reg(0, 8'hEE);
        load_ir(mk(0, 0, 0, 8'h00)); settle();
        chk("R2 reg0 reads zero", 32'(mem_wdata), 32'h0);

        // R6 / R7 / R2: sweep all register pairs and operations, two data sets
        for (int r = 0; r < 2; r++) begin
            for (int k = 1; k < 8; k++) write_reg(k, val_of(r, k));
            for (int k = 1; k < 8; k++) begin
                load_ir(mk(0, k, 0, 8'h00)); settle();
                chk("R2 read port 2", 32'(mem_wdata), 32'(model_reg[k]));
            end
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    for (int o = 0; o < 5; o++)
                        alu_vec(a, b, op_of(o));
        end

        // R2: a write with reg_we low has no effect
        load_ir(mk(0, 0, 5, 8'h00));
        dst_sel = 1; wb_mem_sel = 1; mem_rdata = 8'h11; tick(); tick();
        load_ir(mk(0, 5, 0, 8'h00)); settle();
        chk("R2 disabled write ignored", 32'(mem_wdata), 32'(model_reg[5]));

        // R3: dst_sel low writes the rt field, rd untouched
        load_ir(mk(0, 6, 2, 8'h00));
        dst_sel = 0; wb_mem_sel = 1; mem_rdata = 8'h6D; tick();
        reg_we = 1; tick(); reg_we = 0; model_reg[6] = 8'h6D;
        load_ir(mk(0, 6, 0, 8'h00)); settle();
        chk("R3 rt destination", 32'(mem_wdata), 32'h6D);
        load_ir(mk(0, 2, 0, 8'h00)); settle();
        chk("R3 rd untouched", 32'(mem_wdata), 32'(model_reg[2]));

        // R8 / R11: immediate add written back through the ALU holding path
        load_ir(mk(3, 0, 7, 8'h9C));
        srca_sel = 1; srcb_sel = 2'b10; alu_op = 3'b010;
        e = model_reg[3] + 8'h9C;
        tick();
        dst_sel = 1; wb_mem_sel = 0; reg_we = 1; tick(); reg_we = 0;
        model_reg[7] = e;
        load_ir(mk(0, 7, 0, 8'h00)); settle();
        chk("R11 alu write-back", 32'(mem_wdata), 32'(e));

        // R8: scaled immediate on operand B
        load_ir(mk(1, 0, 0, 8'hF3));
        srca_sel = 1; srcb_sel = 2'b11; alu_op = 3'b010; tick();
        addr_sel = 1; settle();
        chk("R8 scaled immediate", 32'(mem_addr), 32'(model_reg[1] + 8'hCC));
        addr_sel = 0;

        // R8: program counter plus immediate
        srca_sel = 0; srcb_sel = 2'b10; settle();
        chk("R8 pc operand", 32'(zero), 32'(8'(8'd4 + 8'hF3) == 0));
        tick(); addr_sel = 1; settle();
        chk("R10 alu register addr", 32'(mem_addr), 32'(8'(8'd4 + 8'hF3)));
        addr_sel = 0;

        // R9: counter from registered ALU result
        load_ir(mk(4, 0, 0, 8'h21));
        srca_sel = 1; srcb_sel = 2'b10; alu_op = 3'b010;
        e = model_reg[4] + 8'h21;
        tick();
        pc_src = 2'b01; pc_en = 1; tick(); pc_en = 0; settle();
        chk("R9 pc from alu register", 32'(mem_addr), 32'(e));

        // R9: jump target from the low instruction bits
        load_ir(mk(0, 0, 0, 8'hB7));
        pc_src = 2'b10; pc_en = 1; tick(); pc_en = 0; settle();
        chk("R9 jump target", 32'(mem_addr), 32'hDC);

        // R9: live ALU result (subtract) as the branch-style source
        load_ir(mk(0, 0, 0, 8'h05));
        pc_src = 2'b00; srca_sel = 0; srcb_sel = 2'b10; alu_op = 3'b110;
        pc_en = 1; tick(); pc_en = 0; settle();
        chk("R9 pc from live alu", 32'(mem_addr), 32'(8'hDC - 8'h05));

        // R1: reset in mid-run
        rst_n = 0; tick(); rst_n = 1; settle();
        chk("R1 reset mid-run pc", 32'(mem_addr), 32'h0);
        chk("R1 reset mid-run instr", instr, 32'h0);
        addr_sel = 1; settle();
        chk("R1 reset alu register", 32'(mem_addr), 32'h0);

        summary();
        $finish;
    end

endmodule